// File: doc/BRIEF.md
# Multi-Channel PWM DAC Generator

This block drives a bank of pulse-width-modulated outputs. Each output, after an external low-pass filter, serves as a simple digital-to-analog converter. Every channel holds its own 8-bit duty code. All channels compare that code against one shared step counter, so every channel starts a new period on the same clock edge. A clock prescaler sets the step rate. One mode input doubles the rate. A second mode input shortens the period from 256 steps to 253 steps. In the shorter mode the three highest codes produce a steady high level.

Software-side logic writes duty codes through a simple port that carries a channel index and a data byte. Each write lands in a per-channel holding register. It is copied into the active compare register only when the next period begins, so a write arriving mid-period can never produce a runt pulse. Both mode inputs are plain levels supplied by the surrounding logic.

Top module: `pwm_dac_bank`

## Requirements
- R1: After reset every output is low. An output stays low until a nonzero code is written to its channel and a new period has begun.
- R2: In every period a channel is high for the first D steps, where D is its active code. The output is high while the shared step count is below D.
- R3: The step length is PRESCALE clock cycles when `rate_fast` is 1 and 2*PRESCALE clock cycles when it is 0.
- R4: The period is 256 steps when `short_period` is 0 and 253 steps when it is 1. The step count returns to 0 after step 255 or step 252 respectively.
- R5: With `short_period` = 1, codes 253, 254 and 255 (FDh to FFh) give a continuous high output with no low step.
- R6: With `short_period` = 0, code 255 (FFh) gives an output that is low for exactly one step per period.
- R7: Code 0 gives a continuous low output in both period modes.
- R8: A written code takes effect only at the start of the next period. Every complete high pulse has either the old width or the new width.
- R9: A write with `wr_en` = 1 updates only the channel named by `wr_ch`. All other channels keep their codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Duty code write strobe |
| wr_ch | input | CH_W | Channel index for the write |
| wr_data | input | 8 | Duty code to write |
| rate_fast | input | 1 | 1: double step rate; 0: base rate |
| short_period | input | 1 | 1: 253-step period; 0: 256-step period |
| pwm_out | output | NUM_CH | Registered PWM outputs, one bit per channel |

## Verification
A written code shows up at the outputs only after the current period ends. Each output is registered one cycle behind the step counter. For these reasons the bench waits two full periods plus a margin after any write or mode change before it measures. High time is counted over a window exactly one period long, and in a periodic waveform that count does not depend on where the window starts. Period length is taken as the spacing between two rising edges. The glitch-free update is checked by recording the width of every complete high pulse across the moment of a write. All outputs are sampled on the falling clock edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CODE_W    = 8;
  localparam int SHORT_TOP = 253;   // clamp value and step count of the short period

  // Compare limit seen by a channel: short mode caps codes at the period length.
  function automatic logic [CODE_W-1:0] cmp_limit(input logic [CODE_W-1:0] code,
                                                  input logic short_mode);
    if (short_mode && code > CODE_W'(SHORT_TOP))
      return CODE_W'(SHORT_TOP);
    return code;
  endfunction
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_fast,
  output logic step_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] div_cnt;
  logic          half_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt   <= '0;
      half_ph   <= 1'b0;
      step_tick <= 1'b0;
    end else begin
      step_tick <= 1'b0;
      if (div_cnt == CW'(DIV - 1)) begin
        div_cnt   <= '0;
        half_ph   <= ~half_ph;
        step_tick <= rate_fast | half_ph;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_step_ctr.sv
module pwm_step_ctr
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step_tick,
  input  logic              short_period,
  output logic [CODE_W-1:0] step_cnt,
  output logic              period_load
);
  logic [CODE_W-1:0] last_step;

  assign last_step   = short_period ? CODE_W'(SHORT_TOP - 1) : {CODE_W{1'b1}};
  assign period_load = step_tick && (step_cnt >= last_step);

  always_ff @(posedge clk) begin
    if (rst)
      step_cnt <= '0;
    else if (period_load)
      step_cnt <= '0;
    else if (step_tick)
      step_cnt <= step_cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              period_load,
  input  logic              short_period,
  input  logic [CODE_W-1:0] step_cnt,
  output logic [CODE_W-1:0] act_code,
  output logic              pwm_q
);
  logic [CODE_W-1:0] hold_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_code <= '0;
      act_code  <= '0;
      pwm_q     <= 1'b0;
    end else begin
      if (wr_sel)
        hold_code <= wr_data;
      if (period_load)
        act_code <= hold_code;
      pwm_q <= step_cnt < cmp_limit(act_code, short_period);
    end
  end
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
  import pwm_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int PRESCALE = 4,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              rate_fast,
  input  logic              short_period,
  output logic [NUM_CH-1:0] pwm_out
);
  logic                     step_tick;
  logic                     period_load;
  logic [CODE_W-1:0]        step_cnt;
  logic [NUM_CH*CODE_W-1:0] act_flat;

  pwm_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .rate_fast(rate_fast), .step_tick(step_tick)
  );

  pwm_step_ctr u_ctr (
    .clk(clk), .rst(rst), .step_tick(step_tick), .short_period(short_period),
    .step_cnt(step_cnt), .period_load(period_load)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_channel u_ch (
      .clk(clk), .rst(rst),
      .wr_sel(wr_en && (wr_ch == CH_W'(i))),
      .wr_data(wr_data),
      .period_load(period_load),
      .short_period(short_period),
      .step_cnt(step_cnt),
      .act_code(act_flat[i*CODE_W +: CODE_W]),
      .pwm_q(pwm_out[i])
    );
  end
endmodule

// File: rtl/pwm_dac_bank_chk.sv
module pwm_dac_bank_chk #(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                short_period,
  input logic                step_tick,
  input logic [7:0]          step_cnt,
  input logic [NUM_CH*8-1:0] act_flat,
  input logic [NUM_CH-1:0]   pwm_out
);
  p_cnt_holds_r3: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(step_cnt));

  p_short_range_r4: assert property (@(posedge clk) disable iff (rst)
    (short_period && step_cnt <= 8'd252) |=> step_cnt <= 8'd252);

  p_load_at_start_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_flat) |-> step_cnt == 8'd0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_zero_low_r7: assert property (@(posedge clk) disable iff (rst)
      act_flat[i*8 +: 8] == 8'd0 |=> !pwm_out[i]);

    p_full_high_r5: assert property (@(posedge clk) disable iff (rst)
      (short_period && step_cnt <= 8'd252 && act_flat[i*8 +: 8] >= 8'd253) |=> pwm_out[i]);

    p_top_low_r6: assert property (@(posedge clk) disable iff (rst)
      (!short_period && step_cnt == 8'd255) |=> !pwm_out[i]);
  end
endmodule

bind pwm_dac_bank pwm_dac_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .short_period(short_period), .step_tick(step_tick),
  .step_cnt(step_cnt), .act_flat(act_flat), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_dac_bank.sv
module sim_pwm_dac_bank;
  localparam int NCH = 4;
  localparam int PRE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_ch = '0;
  logic [7:0] wr_data = '0;
  logic       rate_fast = 1'b0;
  logic       short_period = 1'b0;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  int hi [NCH];
  bit done = 0;

  always #10 clk = ~clk;

  pwm_dac_bank #(.NUM_CH(NCH), .PRESCALE(PRE)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rate_fast(rate_fast), .short_period(short_period), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int step_clks();
    return rate_fast ? PRE : 2 * PRE;
  endfunction

  function automatic int steps();
    return short_period ? 253 : 256;
  endfunction

  task automatic write_ch(input int ch, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_data = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2 * steps() * step_clks() + 20) @(negedge clk);
  endtask

  task automatic measure();
    for (int c = 0; c < NCH; c++) hi[c] = 0;
    repeat (steps() * step_clks()) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (pwm_out[c]) hi[c]++;
    end
  endtask

  task automatic rise_gap(input int ch, output int gap);
    bit prev;
    int n;
    gap = -1;
    prev = pwm_out[ch];
    n = 0;
    while (n < 6000 && !(pwm_out[ch] && !prev)) begin
      prev = pwm_out[ch]; @(negedge clk); n++;
    end
    gap = 0;
    prev = pwm_out[ch];
    @(negedge clk); gap++;
    while (gap < 6000 && !(pwm_out[ch] && !prev)) begin
      prev = pwm_out[ch]; @(negedge clk); gap++;
    end
  endtask

  task automatic t_reset();
    bit any_hi = 0;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check(pwm_out == '0, "R1 in reset", int'(pwm_out), 0);
    rst = 1'b0;
    repeat (3000) begin
      @(negedge clk);
      if (pwm_out != '0) any_hi = 1;
    end
    check(!any_hi, "R1 idle after reset", int'(any_hi), 0);
  endtask

  task automatic t_default();
    write_ch(0, 8'h80); write_ch(1, 8'h40); write_ch(2, 8'h01); write_ch(3, 8'h00);
    settle(); measure();
    check(hi[0] == 128 * 8, "R2 ch0 slow", hi[0], 128 * 8);
    check(hi[1] == 64 * 8,  "R3 ch1 slow step", hi[1], 64 * 8);
    check(hi[2] == 8,       "R9 ch2 slow", hi[2], 8);
    check(hi[3] == 0,       "R7 ch3 zero", hi[3], 0);
  endtask

  task automatic t_fast();
    int gap;
    rate_fast = 1'b1;
    write_ch(3, 8'h20);
    settle(); measure();
    check(hi[0] == 128 * 4, "R3 ch0 fast", hi[0], 128 * 4);
    check(hi[1] == 64 * 4,  "R9 ch1 untouched", hi[1], 64 * 4);
    check(hi[3] == 32 * 4,  "R9 ch3 written", hi[3], 32 * 4);
    rise_gap(3, gap);
    check(gap == 256 * 4, "R4 long period", gap, 256 * 4);
  endtask

  task automatic t_full_long();
    write_ch(0, 8'hFF); write_ch(1, 8'hFE);
    settle(); measure();
    check(hi[0] == 255 * 4, "R6 FFh one low step", hi[0], 255 * 4);
    check(hi[1] == 254 * 4, "R2 FEh long", hi[1], 254 * 4);
  endtask

  task automatic t_short();
    int gap;
    short_period = 1'b1;
    write_ch(0, 8'hFD); write_ch(1, 8'hFE); write_ch(2, 8'hFF); write_ch(3, 8'h10);
    settle(); measure();
    check(hi[0] == 253 * 4, "R5 FDh steady", hi[0], 253 * 4);
    check(hi[1] == 253 * 4, "R5 FEh steady", hi[1], 253 * 4);
    check(hi[2] == 253 * 4, "R5 FFh steady", hi[2], 253 * 4);
    check(hi[3] == 16 * 4,  "R2 short 10h", hi[3], 16 * 4);
    rise_gap(3, gap);
    check(gap == 253 * 4, "R4 short period", gap, 253 * 4);
  endtask

  task automatic t_zero();
    for (int c = 0; c < NCH; c++) write_ch(c, 0);
    settle(); measure();
    check(hi[0] + hi[1] + hi[2] + hi[3] == 0, "R7 zero short", hi[0] + hi[2], 0);
    short_period = 1'b0;
    settle(); measure();
    check(hi[0] + hi[1] + hi[2] + hi[3] == 0, "R7 zero long", hi[0] + hi[2], 0);
  endtask

  task automatic t_shadow();
    int run, bad, saw_new;
    bit prev;
    write_ch(0, 8'h20);
    settle();
    repeat (300) @(negedge clk);
    write_ch(0, 8'h60);
    run = 0; bad = 0; saw_new = 0; prev = pwm_out[0];
    repeat (3 * 256 * 4) begin
      @(negedge clk);
      if (pwm_out[0]) run++;
      else if (prev) begin
        if (run == 96 * 4) saw_new = 1;
        else if (run != 32 * 4) bad = run;
        run = 0;
      end
      prev = pwm_out[0];
    end
    check(bad == 0, "R8 no runt pulse", bad, 0);
    check(saw_new == 1, "R8 new width applied", saw_new, 1);
  endtask

  initial begin
    #(4_000_000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_default();
    t_fast();
    t_full_long();
    t_short();
    t_zero();
    t_shadow();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule